// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time

This block is one pulse-width-modulation channel that drives a complementary pair of outputs: a high-side output and a low-side output. A counter advances on each cycle where an external prescaler raises a clock-enable strobe. The counter is compared with a duty value to form a reference level. The high side follows the reference and the low side follows its complement. Each side has its own dead-time, which holds back that side's rising edge so that the two switches never conduct together. The counter can run in two ways. In edge mode it counts from zero up to one below the period. In symmetric mode it counts up to the period and back down again.

Period, duty, dead-time and mode are loaded through a small register-write port. While the channel is stopped, a write lands in the working registers at once. While it runs, a write is held in a staging copy, and that copy is moved into the working registers at the next period boundary. Duty and dead-time values are limited to the period when they are written. A stop request is not acted on at once: the channel completes the period in progress and then clears its running flag. Every period boundary also produces a one-cycle pulse that can serve as an interrupt source.

Top module: `pwmdt_channel`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_hi, out_lo, running and period_end are all 0.
- R2: Edge mode (mode bit 0 = 0): with the strobe high every cycle and period P, one period lasts P strobes. The reference is active while the counter is below the duty value D, so it is active for D of the P strobes. period_end pulses exactly once per period.
- R3: Symmetric mode (mode bit 0 = 1): the counter runs 0 up to P and back down to 1, so one period lasts 2P strobes. The reference is active while the counter is below D, which gives 2D-1 active strobes per period when D is at least 1.
- R4: Mode bit 1 set inverts the reference, so the high side follows the counter being at or above D and the low side follows the counter being below D.
- R5: With mode bit 2 (dead-time enable) set, the high output rises only after its raw level has been high for the high dead-time number of strobes. The low output does the same with the low dead-time. The dead-time write (select 3) carries the high value in data bits [15:0] and the low value in bits [31:16]. When both inversion bits are 0, out_hi and out_lo are never 1 together.
- R6: Mode bit 3 inverts out_hi and mode bit 4 inverts out_lo, after dead-time insertion.
- R7: The write selects are 0 = mode, 1 = period, 2 = duty, 3 = dead-time. A period, duty or dead-time write while stopped takes effect at once. The same write while running takes effect only from the next period boundary.
- R8: A duty or dead-time value larger than the staged period is stored as the period.
- R9: After a stop request (dis_req), running stays 1 until the period in progress ends. running falls in the same cycle that period_end is 1.
- R10: A mode write made while running has no effect.
- R11: While stopped, out_hi equals mode bit 3 and out_lo equals mode bit 4.
- R12: en_req while stopped starts the counter at zero. In edge mode with the strobe high every cycle, the first period_end appears P cycles after the edge that samples en_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock-enable from the prescaler |
| en_req | input | 1 | Start request (one cycle) |
| dis_req | input | 1 | Stop request, honoured at the end of the period in progress |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 period, 2 duty, 3 dead-time |
| wr_data | input | 32 | Write data |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side output |
| running | output | 1 | Channel is running |
| period_end | output | 1 | One-cycle pulse at each period boundary |

## Verification
The bench builds the channel with an 8-bit counter. This keeps every period short enough to measure whole periods in both counting modes, and a write of 100 is still well above the small periods in use, so both limiting paths are taken. Most tests raise the strobe every cycle so that windows and gaps can be counted exactly. One dead-time test raises it every third cycle, to show that dead-time and period are counted in strobes and not in clocks. Symmetric mode is driven with duty equal to the period, so the single low strobe at the top of the count is visible.

// File: rtl/pwmdt_pkg.sv
package pwmdt_pkg;
  localparam int DATA_W    = 32;
  localparam int MODE_W    = 5;
  localparam int DT_LO_LSB = 16;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_DUTY   = 2'd2,
    SEL_DEAD   = 2'd3
  } sel_e;

  // packed MSB first: centre sits in bit 0
  typedef struct packed {
    logic inv_lo;
    logic inv_hi;
    logic dt_en;
    logic ref_inv;
    logic centre;
  } mode_t;
endpackage

// File: rtl/pwmdt_regs.sv
module pwmdt_regs
  import pwmdt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              running,
  input  logic              load,
  output mode_t             mode_q,
  output logic [CW-1:0]     act_prd,
  output logic [CW-1:0]     act_duty,
  output logic [CW-1:0]     act_dth,
  output logic [CW-1:0]     act_dtl
);
  logic [CW-1:0] sh_prd, sh_duty, sh_dth, sh_dtl;
  logic [CW-1:0] v_main, v_lo, c_duty, c_dth, c_dtl;

  function automatic logic [CW-1:0] cap_to(input logic [CW-1:0] v, input logic [CW-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  always_comb begin
    v_main = wr_data[CW-1:0];
    v_lo   = wr_data[DT_LO_LSB +: CW];
    c_duty = cap_to(v_main, sh_prd);
    c_dth  = cap_to(v_main, sh_prd);
    c_dtl  = cap_to(v_lo, sh_prd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      sh_prd   <= '0;
      sh_duty  <= '0;
      sh_dth   <= '0;
      sh_dtl   <= '0;
      act_prd  <= '0;
      act_duty <= '0;
      act_dth  <= '0;
      act_dtl  <= '0;
    end else begin
      if (load) begin
        act_prd  <= sh_prd;
        act_duty <= sh_duty;
        act_dth  <= sh_dth;
        act_dtl  <= sh_dtl;
      end
      if (wr_en) begin
        case (sel_e'(wr_sel))
          SEL_MODE: if (!running) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
          SEL_PERIOD: begin
            sh_prd <= v_main;
            if (!running) act_prd <= v_main;
          end
          SEL_DUTY: begin
            sh_duty <= c_duty;
            if (!running) act_duty <= c_duty;
          end
          default: begin
            sh_dth <= c_dth;
            sh_dtl <= c_dtl;
            if (!running) begin
              act_dth <= c_dth;
              act_dtl <= c_dtl;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pwmdt_counter.sv
module pwmdt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          centre,
  input  logic [CW-1:0] prd,
  output logic [CW-1:0] cnt,
  output logic          bnd,
  output logic          running,
  output logic          period_end
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          up_q, up_nx, stop_pend;
  logic [CW-1:0] cnt_nx;

  always_comb begin
    bnd    = 1'b0;
    cnt_nx = cnt;
    up_nx  = up_q;
    if (running && tick) begin
      if (prd == '0) begin
        cnt_nx = '0;
        up_nx  = 1'b1;
        bnd    = 1'b1;
      end else if (!centre) begin
        if (cnt >= prd - ONE) begin
          cnt_nx = '0;
          bnd    = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else if (up_q) begin
        if (cnt >= prd) begin
          cnt_nx = cnt - ONE;
          if (prd == ONE) begin
            bnd = 1'b1;
          end else begin
            up_nx = 1'b0;
          end
        end else begin
          cnt_nx = cnt + ONE;
        end
      end else begin
        if (cnt <= ONE) begin
          cnt_nx = '0;
          up_nx  = 1'b1;
          bnd    = 1'b1;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      up_q       <= 1'b1;
      running    <= 1'b0;
      stop_pend  <= 1'b0;
      period_end <= 1'b0;
    end else begin
      period_end <= bnd;
      if (!running) begin
        if (en_req) begin
          running   <= 1'b1;
          cnt       <= '0;
          up_q      <= 1'b1;
          stop_pend <= 1'b0;
        end
      end else begin
        cnt  <= cnt_nx;
        up_q <= up_nx;
        if (dis_req) stop_pend <= 1'b1;
        else if (en_req) stop_pend <= 1'b0;
        if (bnd && (stop_pend || dis_req)) begin
          running   <= 1'b0;
          stop_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwmdt_deadband.sv
module pwmdt_deadband #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          raw,
  input  logic          dt_en,
  input  logic          inv,
  input  logic [CW-1:0] dt,
  output logic          out
);
  logic [CW-1:0] hold;
  logic          lvl;

  assign lvl = raw && (!dt_en || (hold >= dt));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      out  <= 1'b0;
    end else begin
      if (!raw) hold <= '0;
      else if (tick && (hold < dt)) hold <= hold + CW'(1);
      out <= lvl ^ inv;
    end
  end
endmodule

// File: rtl/pwmdt_channel.sv
module pwmdt_channel
  import pwmdt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_hi,
  output logic              out_lo,
  output logic              running,
  output logic              period_end
);
  localparam int SIDES = 2;

  mode_t         mode_q;
  logic [CW-1:0] act_prd, act_duty, act_dth, act_dtl, cnt;
  logic          bnd, ref_on;
  logic [SIDES-1:0] raw_s, inv_s, out_s;
  logic [CW-1:0] dt_s [SIDES];

  pwmdt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .running(running), .load(bnd), .mode_q(mode_q),
    .act_prd(act_prd), .act_duty(act_duty), .act_dth(act_dth), .act_dtl(act_dtl)
  );

  pwmdt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .en_req(en_req), .dis_req(dis_req),
    .centre(mode_q.centre), .prd(act_prd), .cnt(cnt), .bnd(bnd),
    .running(running), .period_end(period_end)
  );

  assign ref_on   = (cnt < act_duty) ^ mode_q.ref_inv;
  assign raw_s[0] = running & ref_on;
  assign raw_s[1] = running & ~ref_on;
  assign inv_s[0] = mode_q.inv_hi;
  assign inv_s[1] = mode_q.inv_lo;
  assign dt_s[0]  = act_dth;
  assign dt_s[1]  = act_dtl;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    pwmdt_deadband #(.CW(CW)) u_db (
      .clk(clk), .rst(rst), .tick(tick), .raw(raw_s[s]), .dt_en(mode_q.dt_en),
      .inv(inv_s[s]), .dt(dt_s[s]), .out(out_s[s])
    );
  end

  assign out_hi = out_s[0];
  assign out_lo = out_s[1];
endmodule

// File: rtl/pwmdt_channel_chk.sv
module pwmdt_channel_chk (
  input logic clk,
  input logic rst,
  input logic en_req,
  input logic out_hi,
  input logic out_lo,
  input logic running,
  input logic period_end,
  input logic inv_hi,
  input logic inv_lo
);
  // R5
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    (!inv_hi && !inv_lo && !$past(inv_hi) && !$past(inv_lo)) |-> !(out_hi && out_lo));

  // R2
  pe_run_chk: assert property (@(posedge clk) disable iff (rst)
    period_end |-> $past(running));

  // R9
  stop_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> period_end);

  // R11
  idle_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> (out_hi == $past(inv_hi)) && (out_lo == $past(inv_lo)));

  // R12
  start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(en_req));
endmodule

bind pwmdt_channel pwmdt_channel_chk u_chk (
  .clk(clk), .rst(rst), .en_req(en_req), .out_hi(out_hi), .out_lo(out_lo),
  .running(running), .period_end(period_end),
  .inv_hi(mode_q.inv_hi), .inv_lo(mode_q.inv_lo)
);

// File: tb/pwmdt_channel_tb.sv
module pwmdt_channel_tb;
  localparam int CLK_P = 10;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic en_req = 1'b0, dis_req = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic out_hi, out_lo, running, period_end;

  int checks = 0;
  int errors = 0;
  int div = 1;
  int ph = 0;

  pwmdt_channel #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .en_req(en_req), .dis_req(dis_req),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .out_hi(out_hi), .out_lo(out_lo), .running(running), .period_end(period_end)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      ph   = (ph + 1 >= div) ? 0 : ph + 1;
      tick = (ph == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pe();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (period_end) return;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (period_end) return;
    end
  endtask

  task automatic stop_ch();
    if (running) begin
      @(negedge clk); dis_req = 1'b1;
      @(negedge clk); dis_req = 1'b0;
      for (int i = 0; i < 2000 && running; i++) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic start_ch();
    @(negedge clk); en_req = 1'b1;
    @(negedge clk); en_req = 1'b0;
    wait_pe();
    wait_pe();
  endtask

  task automatic measure(input int n, output int hi, output int lo, output int pe, output int both);
    hi = 0; lo = 0; pe = 0; both = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(out_hi);
      lo += int'(out_lo);
      pe += int'(period_end);
      both += int'(out_hi && out_lo);
    end
  endtask

  task automatic setup(input int mode, input int p, input int d, input logic [31:0] dt);
    stop_ch();
    wr(0, 32'(mode));
    wr(1, 32'(p));
    wr(2, 32'(d));
    wr(3, dt);
    start_ch();
  endtask

  task automatic t_reset();
    chk("R1 out_hi", int'(out_hi), 0);
    chk("R1 out_lo", int'(out_lo), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 period_end", int'(period_end), 0);
  endtask

  task automatic t_left();
    int hi, lo, pe, bo;
    setup(0, 10, 4, 0);
    measure(10, hi, lo, pe, bo);
    chk("R2 hi", hi, 4); chk("R2 lo", lo, 6); chk("R2 pulses", pe, 1);
    setup(0, 10, 0, 0);
    measure(10, hi, lo, pe, bo);
    chk("R2 zero duty hi", hi, 0); chk("R2 zero duty lo", lo, 10);
  endtask

  task automatic t_centre();
    int hi, lo, pe, bo;
    setup(1, 6, 3, 0);
    measure(12, hi, lo, pe, bo);
    chk("R3 hi", hi, 5); chk("R3 lo", lo, 7); chk("R3 pulses", pe, 1);
  endtask

  task automatic t_polarity();
    int hi, lo, pe, bo;
    setup(2, 10, 4, 0);
    measure(10, hi, lo, pe, bo);
    chk("R4 hi", hi, 6); chk("R4 lo", lo, 4);
  endtask

  task automatic t_deadtime();
    int hi, lo, pe, bo;
    setup(4, 10, 5, {16'd3, 16'd2});
    measure(10, hi, lo, pe, bo);
    chk("R5 hi", hi, 3); chk("R5 lo", lo, 2); chk("R5 overlap", bo, 0);
    stop_ch();
    div = 3;
    start_ch();
    measure(30, hi, lo, pe, bo);
    chk("R5 slow hi", hi, 9); chk("R5 slow lo", lo, 6);
    stop_ch();
    div = 1;
  endtask

  task automatic t_invert();
    int hi, lo, pe, bo;
    setup(28, 10, 5, {16'd3, 16'd2});
    measure(10, hi, lo, pe, bo);
    chk("R6 hi", hi, 7); chk("R6 lo", lo, 8);
    stop_ch();
    @(negedge clk);
    chk("R11 inverted idle hi", int'(out_hi), 1);
    chk("R11 inverted idle lo", int'(out_lo), 1);
  endtask

  task automatic t_shadow();
    int n;
    setup(0, 10, 4, 0);
    wr(1, 32'd20);
    gap(n);
    chk("R7 old period holds", int'(n <= 10), 1);
    gap(n);
    chk("R7 new period", n, 20);
  endtask

  task automatic t_clamp();
    int hi, lo, pe, bo;
    setup(5, 8, 50, {16'd0, 16'd100});
    measure(16, hi, lo, pe, bo);
    chk("R8 hi", hi, 7); chk("R8 lo", lo, 1);
  endtask

  task automatic t_mode_ignored();
    int hi, lo, pe, bo, n;
    setup(0, 10, 4, 0);
    wr(0, 32'd1);
    wait_pe();
    measure(10, hi, lo, pe, bo);
    chk("R10 hi", hi, 4);
    wait_pe();
    gap(n);
    chk("R10 period", n, 10);
  endtask

  task automatic t_disable();
    int n, pe_at_stop;
    setup(0, 10, 4, 0);
    @(negedge clk); @(negedge clk);
    dis_req = 1'b1;
    @(negedge clk);
    dis_req = 1'b0;
    chk("R9 still running", int'(running), 1);
    n = 0; pe_at_stop = 0;
    for (int i = 0; i < 100 && running; i++) begin
      @(negedge clk);
      n++;
      if (!running) pe_at_stop = int'(period_end);
    end
    chk("R9 stop at boundary", pe_at_stop, 1);
    chk("R9 within period", int'(n <= 10), 1);
    @(negedge clk);
    chk("R11 idle hi", int'(out_hi), 0);
    chk("R11 idle lo", int'(out_lo), 0);
  endtask

  task automatic t_enable();
    int n;
    stop_ch();
    wr(1, 32'd7);
    wr(2, 32'd3);
    @(negedge clk); en_req = 1'b1;
    @(negedge clk); en_req = 1'b0;
    gap(n);
    chk("R12 first pulse", n, 7);
    chk("R7 stopped write direct", n, 7);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_left();
    t_centre();
    t_polarity();
    t_deadtime();
    t_invert();
    t_shadow();
    t_clamp();
    t_mode_ignored();
    t_disable();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule